// File: doc/BRIEF.md
# Serial Octal Output Driver Controller

This block is the digital core of an eight-channel low-side switch. A host talks to it over a four-wire serial link with the clock idling low: data out changes on each clock rising edge, and data in is captured on each falling edge. Each frame carries one bit per channel, most significant bit first. The block keeps an output latch that holds one bit per channel. A latch bit of 0 switches its channel ON and a 1 switches it OFF. While the host shifts in a new setting, the block shifts out the voltage level sensed on each channel pin, so the host can compare what it asked for with what the pins did.

All serial pins are brought into a fast system clock through two-flop synchronizers, and edges are found by comparing each synchronized level with its previous sample. The system clock must run at least four times faster than the serial clock. Select going low loads the sensed pin levels into the shift register. Select going high copies the shift register into the latch. Between frames, any channel that is ON and reports an out-of-saturation fault drops its own latch bit to OFF. Frames longer than eight bits pass straight through to the serial output, so several devices can be chained.

The stream style of the project does not fit here. The edge of the block is a serial pin interface with no back-pressure, so every port is a plain level.

Top module: `spi_octal_ctrl`

## Requirements
- R1: The shift register captures `spi_mosi` on each synchronized falling edge of `spi_sck` and shifts toward bit 7. `spi_miso` takes the shift register's bit 7 on each rising edge. Both directions are most significant bit first, and frame bit i belongs to channel i.
- R2: On the falling edge of `spi_cs_n`, the shift register is loaded in parallel from `pin_level` (1 = pin high). The first bit presented on `spi_miso` is `pin_level[7]`.
- R3: On the rising edge of `spi_cs_n`, the shift register is copied into `chan_off`. A bit value of 1 means the channel is OFF and 0 means it is ON.
- R4: While `spi_cs_n` is high, `spi_miso_oe` is 0, and toggling `spi_sck` or `spi_mosi` has no effect on `chan_off`.
- R5: When `rst_n` is low, `chan_off` becomes all ones at once, with no clock edge needed. After release it stays all ones until a frame is completed.
- R6: A channel whose latch bit is 0 and whose `sat_fault` bit is 1 on a clock edge has its latch bit set to 1 at that edge. Other channels are untouched. A fault on an OFF channel leaves no trace, so a later write can turn that channel ON.
- R7: In a frame longer than 8 bits, the bits shifted in appear on `spi_miso` after the 8 sensed bits, and the latch takes the last 8 bits written.
- R8: If select rises after a number of falling edges that is not a multiple of 8, the partly shifted register is latched as it stands. That value is the remaining jam bits in the upper positions and the new bits in the lower positions.
- R9: A change on a serial pin takes effect at the third system clock edge after the change. Two edges pass through the synchronizer and the third edge updates the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data in |
| pin_level | input | NCH | Sensed output pin levels, 1 = high |
| sat_fault | input | NCH | Out-of-saturation flags, one per channel |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` (0 = high impedance) |
| chan_off | output | NCH | Output latch, 1 = channel OFF |

## Verification
The bench builds the block with its default parameters: eight channels, two synchronizer stages, and a serial clock eight times slower than the system clock. With these values the exact three-edge latency of R9 can be checked on every clock. It also keeps whole-byte, short (3-bit and 11-bit) and 16-bit chained frames within a short run. Fault pulses of a single clock reach both ON and OFF channels, so the per-channel drop and its absence are both observed on `chan_off`.

// File: rtl/spi_oct_pkg.sv
package spi_oct_pkg;
  localparam int unsigned CH_DEFAULT   = 8;
  localparam int unsigned SYNC_DEFAULT = 2;

  // Events derived from synchronized serial pins, one cycle wide.
  typedef struct packed {
    logic cs_high;
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
    logic mosi;
  } spi_evt_t;
endpackage

// File: rtl/oct_pin_sync.sv
module oct_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  localparam int unsigned TOP = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= {STAGES{RST_VAL[b]}};
        prev_q <= RST_VAL[b];
      end else begin
        chain  <= {chain[STAGES-2:0], din[b]};
        prev_q <= chain[TOP];
      end
    end
    assign dout[b]  = chain[TOP];
    assign dprev[b] = prev_q;
  end
endmodule

// File: rtl/oct_shift_reg.sv
module oct_shift_reg
  import spi_oct_pkg::*;
#(
  parameter int unsigned NCH = CH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  spi_evt_t       evt,
  input  logic [NCH-1:0] pin_level,
  output logic [NCH-1:0] sr_q,
  output logic           miso_q
);
  localparam int unsigned MSB = NCH - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      miso_q <= 1'b1;
    end else if (evt.cs_fall) begin
      sr_q   <= pin_level;
      miso_q <= pin_level[MSB];
    end else if (evt.sck_fall) begin
      sr_q   <= {sr_q[MSB-1:0], evt.mosi};
    end else if (evt.sck_rise) begin
      miso_q <= sr_q[MSB];
    end
  end

  // R2: parallel jam of sensed levels at select fall
  p_jam_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_fall |=> (sr_q == $past(pin_level)));

  // R1: one-place shift with the captured data bit entering at bit 0
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sck_fall |=> (sr_q == {$past(sr_q[MSB-1:0]), $past(evt.mosi)}));

  // R4: deselected device keeps its register
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_high |=> $stable(sr_q));
endmodule

// File: rtl/oct_out_latch.sv
module oct_out_latch
  import spi_oct_pkg::*;
#(
  parameter int unsigned NCH = CH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [NCH-1:0] sr_i,
  input  logic [NCH-1:0] fault_i,
  output logic [NCH-1:0] lat_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lat_q[i] <= 1'b1;
      else if (upd)                    lat_q[i] <= sr_i[i];
      else if (!lat_q[i] && fault_i[i]) lat_q[i] <= 1'b1;
    end
  end

  // R3: select rise copies the shift register
  p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (lat_q == $past(sr_i)));

  // R6: faulted ON channels drop, nothing else moves
  p_fault_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (lat_q == ($past(lat_q) | ($past(fault_i) & ~$past(lat_q)))));

  // R5: everything OFF on the first edge after reset
  p_rst_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lat_q == '1));
endmodule

// File: rtl/spi_octal_ctrl.sv
module spi_octal_ctrl
  import spi_oct_pkg::*;
#(
  parameter int unsigned NCH         = CH_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_cs_n,
  input  logic           spi_sck,
  input  logic           spi_mosi,
  input  logic [NCH-1:0] pin_level,
  input  logic [NCH-1:0] sat_fault,
  output logic           spi_miso,
  output logic           spi_miso_oe,
  output logic [NCH-1:0] chan_off
);
  localparam int unsigned NPIN = 3;
  localparam int unsigned B_CS = 2, B_SCK = 1, B_MOSI = 0;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

  logic [NPIN-1:0] pin_s, pin_p;
  spi_evt_t        evt;
  logic [NCH-1:0]  sr;
  logic            miso_q;

  oct_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_cs_n, spi_sck, spi_mosi}),
    .dout (pin_s),
    .dprev(pin_p)
  );

  always_comb begin
    evt.cs_high  = pin_s[B_CS];
    evt.cs_fall  = pin_p[B_CS] & ~pin_s[B_CS];
    evt.cs_rise  = ~pin_p[B_CS] & pin_s[B_CS];
    evt.sck_rise = ~pin_s[B_CS] & ~pin_p[B_SCK] & pin_s[B_SCK];
    evt.sck_fall = ~pin_s[B_CS] & pin_p[B_SCK] & ~pin_s[B_SCK];
    evt.mosi     = pin_s[B_MOSI];
  end

  oct_shift_reg #(.NCH(NCH)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .pin_level(pin_level),
    .sr_q     (sr),
    .miso_q   (miso_q)
  );

  oct_out_latch #(.NCH(NCH)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (evt.cs_rise),
    .sr_i   (sr),
    .fault_i(sat_fault),
    .lat_q  (chan_off)
  );

  assign spi_miso    = miso_q;
  assign spi_miso_oe = ~pin_s[B_CS];

  // R4: output driver off whenever the select pin has been high for two edges
  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n) && spi_cs_n) |=> !spi_miso_oe);
endmodule

// File: tb/spi_octal_ctrl_tb_top.sv
module spi_octal_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int HALF   = 4;   // system clocks per serial half period
  localparam int N      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [N-1:0] pin_level = '0, sat_fault = '0;
  logic miso, miso_oe;
  logic [N-1:0] chan_off;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  spi_octal_ctrl #(.NCH(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .pin_level(pin_level), .sat_fault(sat_fault),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .chan_off(chan_off)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference, compared each clock ----------------
  logic [2:0] hq[$];           // pins {cs,sck,mosi} seen at each edge
  logic [N-1:0] m_sr, m_lat;
  logic m_miso;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_sr = '1; m_lat = '1; m_miso = 1'b1;
      hq = {3'b100, 3'b100, 3'b100};
    end else begin
      logic [2:0] cur, prv;
      logic [N-1:0] nsr, nlat;
      logic nmiso;
      hq.push_back({cs_n, sck, mosi});
      if (hq.size() > 4) void'(hq.pop_front());
      cur = hq[hq.size()-3];   // R9: level two edges old
      prv = hq[hq.size()-4];
      nsr = m_sr; nlat = m_lat; nmiso = m_miso;
      if (prv[2] && !cur[2]) begin
        nsr = pin_level; nmiso = pin_level[N-1];
      end else if (!cur[2] && prv[1] && !cur[1]) begin
        nsr = {m_sr[N-2:0], cur[0]};
      end else if (!cur[2] && !prv[1] && cur[1]) begin
        nmiso = m_sr[N-1];
      end
      if (!prv[2] && cur[2]) nlat = m_sr;
      else for (int i = 0; i < N; i++) if (!m_lat[i] && sat_fault[i]) nlat[i] = 1'b1;
      m_sr = nsr; m_lat = nlat; m_miso = nmiso;
    end
    if (!done) begin
      logic exp_oe;
      exp_oe = rst_n ? !hq[hq.size()-2][2] : 1'b0;
      chk(chan_off === m_lat, "R3 R6 R9 model latch", 32'(chan_off), 32'(m_lat));
      chk(miso_oe === exp_oe, "R4 model oe", 32'(miso_oe), 32'(exp_oe));
      if (exp_oe) chk(miso === m_miso, "R1 R2 model miso", 32'(miso), 32'(m_miso));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Shift nbits (MSB first) and check the latch timing at select rise.
  task automatic frame(input int nbits, input logic [31:0] data,
                       output logic [31:0] got, input logic [N-1:0] exp_lat,
                       input string tag);
    logic [N-1:0] old;
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    wclk(HALF);
    for (int b = nbits - 1; b >= 0; b--) begin
      mosi = data[b]; sck = 1'b1;
      wclk(HALF);
      got[b] = miso;
      sck = 1'b0;
      wclk(HALF);
    end
    old = chan_off;
    cs_n = 1'b1;
    @(posedge clk); #1 chk(chan_off === old, {tag, " R9 edge1 old"}, 32'(chan_off), 32'(old));
    @(posedge clk); #1 chk(chan_off === old, {tag, " R9 edge2 old"}, 32'(chan_off), 32'(old));
    @(posedge clk); #1 chk(chan_off === exp_lat, {tag, " R3 edge3 new"}, 32'(chan_off), 32'(exp_lat));
    wclk(HALF);
  endtask

  task automatic pulse_fault(input logic [N-1:0] f);
    @(negedge clk); sat_fault = f;
    @(negedge clk); sat_fault = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    wclk(3);
    // R5 reset state
    chk(chan_off === 8'hFF, "R5 reset all off", 32'(chan_off), 32'hFF);
    chk(miso_oe === 1'b0, "R4 reset oe", 32'(miso_oe), 0);
    @(negedge clk) rst_n = 1'b1;
    wclk(10);
    chk(chan_off === 8'hFF, "R5 off after release", 32'(chan_off), 32'hFF);

    // R1 R2 R3 basic byte
    pin_level = 8'h3C;
    frame(8, 32'hA5, got, 8'hA5, "R3 byte A5");
    chk(got[7:0] === 8'h3C, "R2 R1 sensed byte out", got, 32'h3C);
    chk(chan_off === 8'hA5, "R3 latch A5", 32'(chan_off), 32'hA5);

    pin_level = 8'h5A;
    frame(8, 32'h00, got, 8'h00, "R3 all on");
    chk(got[7:0] === 8'h5A, "R2 sensed 5A", got, 32'h5A);

    // R6 fault on ON channel 2 only
    pulse_fault(8'h04);
    chk(chan_off === 8'h04, "R6 ch2 dropped", 32'(chan_off), 32'h04);
    pulse_fault(8'h84);
    chk(chan_off === 8'h84, "R6 ch7 dropped ch2 stays", 32'(chan_off), 32'h84);

    // R6 faults on OFF channels leave no trace
    pin_level = 8'hF0;
    frame(8, 32'h0F, got, 8'h0F, "R6 setup");
    pulse_fault(8'h0F);
    chk(chan_off === 8'h0F, "R6 off channels ignore fault", 32'(chan_off), 32'h0F);
    frame(8, 32'h00, got, 8'h00, "R6 rewrite on");
    chk(chan_off === 8'h00, "R6 no fault memory", 32'(chan_off), 32'h00);

    // R4 serial activity while deselected
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sck = 1'b1; mosi = k[0];
      wclk(HALF);
      sck = 1'b0;
      wclk(HALF);
      chk(chan_off === 8'h00, "R4 latch ignores sck", 32'(chan_off), 32'h00);
      chk(miso_oe === 1'b0, "R4 oe low deselected", 32'(miso_oe), 0);
    end
    mosi = 1'b0;

    // R7 chained 16-bit frame
    pin_level = 8'hC3;
    frame(16, 32'h1E96, got, 8'h96, "R7 chain");
    chk(got[15:8] === 8'hC3, "R7 sensed first", 32'(got[15:8]), 32'hC3);
    chk(got[7:0] === 8'h1E, "R7 pass-through", 32'(got[7:0]), 32'h1E);

    // R8 partial frames
    pin_level = 8'hB2;
    frame(3, 32'h5, got, 8'h95, "R8 three bits");
    chk(chan_off === 8'h95, "R8 partial latched", 32'(chan_off), 32'h95);
    pin_level = 8'h0F;
    frame(11, 32'h5A3, got, 8'hA3, "R8 eleven bits");
    chk(got[10:3] === 8'h0F, "R8 sensed on long partial", 32'(got[10:3]), 32'h0F);

    // R5 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1 chk(chan_off === 8'hFF, "R5 async clear", 32'(chan_off), 32'hFF);
    wclk(3);
    @(negedge clk) rst_n = 1'b1;
    wclk(12);
    chk(chan_off === 8'hFF, "R5 stays off", 32'(chan_off), 32'hFF);
    pin_level = 8'h00;
    frame(8, 32'h7E, got, 8'h7E, "R5 first frame");

    wclk(4);
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule